// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block handles exceptions for a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and write-back. Each stage is held as a register with a valid bit, a program counter and a per-instruction exception record. The record is a flag for each stage that can raise a fault, plus one cause code. A fault reported by a stage is added to the record of the instruction in that stage and moves down the pipeline with it. The fault causes no immediate action.

Action happens only at write-back. When an instruction with a non-empty record arrives there, it is not committed. It is discarded together with every younger instruction. Its PC and cause go into the saved-PC and saved-cause registers, and on the next edge the fetch stage is loaded with the trap vector. Older instructions have already passed write-back, so they complete. Faults are therefore taken in program order, however early a younger instruction flagged its own fault. A return input resumes fetch at the saved PC, so the faulting instruction restarts from scratch. An external interrupt request is attached to the instruction in decode and is then handled like any other fault.

Top module: `exc_pipe_ctrl`

## Requirements
- R1: During and right after reset, only the fetch stage is valid, holding RESET_PC (default 0). Saved PC and saved cause read 0, and trap and commit are low.
- R2: With no redirect, the fetch PC rises by 4 each cycle. The instruction fetched in cycle n sits in write-back in cycle n+4, where commit_o is high if its record is clean.
- R3: A recorded fault causes no action while its instruction is in fetch, decode, execute or memory. trap_o rises only in the cycle that instruction occupies write-back.
- R4: mem_wr_en_o is high only when the memory stage is valid, has no recorded fault, raises none this cycle, and no trap is taken this cycle.
- R5: In a trap cycle the faulting instruction is not committed, and in the next cycle decode through write-back are all empty. Instructions older than the faulting one commit normally.
- R6: The cycle after trap_o, the fetch stage holds TRAP_VEC (default 32'h0000_0080).
- R7: On a trap, epc_o and cause_o load the write-back PC and cause. They hold their value in every other cycle.
- R8: When several instructions flag faults in the same cycle, the oldest one is taken. Its PC and cause are saved.
- R9: stg_exc_i bit k and stg_cause_i bits [4k+3:4k] report the fault of stage k (0 fetch, 1 decode, 2 execute, 3 memory). An instruction that flags in several stages keeps the cause of the first stage that flagged.
- R10: irq_i records a fault on the valid instruction in decode with cause IRQ_CAUSE (default 4'hF). A decode fault flagged in the same cycle supplies the cause instead.
- R11: eret_i loads the fetch stage with epc_o on the next edge and empties decode through write-back. A trap in the same cycle takes priority.
- R12: A fault flag for a stage that holds no valid instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stg_exc_i | input | 4 | Fault flag per stage, bit 0 fetch to bit 3 memory |
| stg_cause_i | input | 16 | Cause code per stage, 4 bits each, stage k at [4k+3:4k] |
| irq_i | input | 1 | External interrupt request, attached to decode |
| eret_i | input | 1 | Return from handler, resume at saved PC |
| fetch_pc_o | output | 32 | PC held in the fetch stage |
| stage_valid_o | output | 5 | Valid bit per stage, bit 0 fetch to bit 4 write-back |
| wb_pc_o | output | 32 | PC held in write-back |
| commit_o | output | 1 | Write-back instruction commits this cycle |
| mem_wr_en_o | output | 1 | Memory stage may perform its write |
| trap_o | output | 1 | Fault taken at write-back this cycle |
| epc_o | output | 32 | Saved PC of the last taken fault |
| cause_o | output | 4 | Saved cause of the last taken fault |

## Verification
The assertions check the following on every cycle: the fetch step of 4, the redirect to the vector after a trap, the resume at the saved PC after a return, the write-enable gate in memory, and the loading and holding of the saved PC. Whether the right instruction is the one taken can only be shown by the bench scenarios. That covers oldest-first selection when faults collide, the first-stage cause rule, interrupt attachment in decode, and the rule that flags on empty stages are ignored. The bench scenarios also show that exactly the older instructions commit around a flush.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PC_W    = 32;
  localparam int CAUSE_W = 4;
  localparam int NSTG    = 5;
  localparam int NRAISE  = NSTG - 1;
  localparam int ID_IDX  = 1;
  localparam int WB_IDX  = NSTG - 1;

  typedef struct packed {
    logic               valid;
    logic [PC_W-1:0]    pc;
    logic [NRAISE-1:0]  flags;
    logic [CAUSE_W-1:0] cause;
  } stage_t;

  function automatic stage_t fetch_entry(input logic [PC_W-1:0] pc);
    stage_t s;
    s       = '0;
    s.valid = 1'b1;
    s.pc    = pc;
    return s;
  endfunction
endpackage

// File: rtl/exc_merge.sv
module exc_merge
  import exc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  stage_t             cur_i,
  input  logic               exc_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output stage_t             nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.valid && exc_i) begin
      nxt_o.flags[IDX] = 1'b1;
      // first stage to flag owns the cause
      if (cur_i.flags == '0) nxt_o.cause = cause_i;
    end
  end
endmodule

// File: rtl/exc_commit.sv
module exc_commit
  import exc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  stage_t             wb_i,
  output logic               trap_o,
  output logic               commit_o,
  output logic [PC_W-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  assign trap_o   = wb_i.valid && (wb_i.flags != '0);
  assign commit_o = wb_i.valid && (wb_i.flags == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= '0;
    end else if (trap_o) begin
      epc_o   <= wb_i.pc;
      cause_o <= wb_i.cause;
    end
  end

  a_r7_epc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (epc_o == $past(wb_i.pc)) && (cause_o == $past(wb_i.cause)));
  a_r7_epc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |=> $stable(epc_o) && $stable(cause_o));
  a_r5_no_commit_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !commit_o);
endmodule

// File: rtl/exc_pipe_ctrl.sv
module exc_pipe_ctrl
  import exc_pkg::*;
#(
  parameter logic [PC_W-1:0]    TRAP_VEC  = 32'h0000_0080,
  parameter logic [PC_W-1:0]    RESET_PC  = 32'h0000_0000,
  parameter logic [CAUSE_W-1:0] IRQ_CAUSE = 4'hF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NRAISE-1:0]         stg_exc_i,
  input  logic [NRAISE*CAUSE_W-1:0] stg_cause_i,
  input  logic                      irq_i,
  input  logic                      eret_i,
  output logic [PC_W-1:0]           fetch_pc_o,
  output logic [NSTG-1:0]           stage_valid_o,
  output logic [PC_W-1:0]           wb_pc_o,
  output logic                      commit_o,
  output logic                      mem_wr_en_o,
  output logic                      trap_o,
  output logic [PC_W-1:0]           epc_o,
  output logic [CAUSE_W-1:0]        cause_o
);
  localparam int MEM_IDX = NRAISE - 1;

  stage_t             stg_q   [NSTG];
  stage_t             mrg     [NRAISE];
  logic [NRAISE-1:0]  exc_eff;
  logic [CAUSE_W-1:0] cause_eff [NRAISE];

  for (genvar g = 0; g < NRAISE; g++) begin : g_raise
    if (g == ID_IDX) begin : g_irq
      assign exc_eff[g]   = stg_exc_i[g] | irq_i;
      assign cause_eff[g] = stg_exc_i[g] ? stg_cause_i[g*CAUSE_W +: CAUSE_W] : IRQ_CAUSE;
    end else begin : g_plain
      assign exc_eff[g]   = stg_exc_i[g];
      assign cause_eff[g] = stg_cause_i[g*CAUSE_W +: CAUSE_W];
    end
    exc_merge #(.IDX(g)) u_mrg (
      .cur_i  (stg_q[g]),
      .exc_i  (exc_eff[g]),
      .cause_i(cause_eff[g]),
      .nxt_o  (mrg[g])
    );
  end

  exc_commit u_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wb_i    (stg_q[WB_IDX]),
    .trap_o  (trap_o),
    .commit_o(commit_o),
    .epc_o   (epc_o),
    .cause_o (cause_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q[0] <= fetch_entry(RESET_PC);
      for (int i = 1; i < NSTG; i++) stg_q[i] <= '0;
    end else if (trap_o || eret_i) begin
      // trap outranks return
      stg_q[0] <= fetch_entry(trap_o ? TRAP_VEC : epc_o);
      for (int i = 1; i < NSTG; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= fetch_entry(stg_q[0].pc + PC_W'(4));
      for (int i = 1; i < NSTG; i++) stg_q[i] <= mrg[i-1];
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_vld
    assign stage_valid_o[s] = stg_q[s].valid;
  end

  assign fetch_pc_o  = stg_q[0].pc;
  assign wb_pc_o     = stg_q[WB_IDX].pc;
  assign mem_wr_en_o = mrg[MEM_IDX].valid && (mrg[MEM_IDX].flags == '0) && !trap_o;

  a_r6_trap_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (fetch_pc_o == TRAP_VEC) && (stage_valid_o == NSTG'(1)));
  a_r11_eret_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !trap_o) |=> (fetch_pc_o == $past(epc_o)) && (stage_valid_o == NSTG'(1)));
  a_r2_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_o && !eret_i) |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(4));
  a_r4_wr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o |-> stage_valid_o[MEM_IDX] && !stg_exc_i[MEM_IDX] && !trap_o);
endmodule

// File: tb/sim_exc_pipe_ctrl.sv
module sim_exc_pipe_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  stg_exc_i = '0;
  logic [15:0] stg_cause_i = '0;
  logic        irq_i = 1'b0;
  logic        eret_i = 1'b0;
  logic [31:0] fetch_pc_o, wb_pc_o, epc_o;
  logic [4:0]  stage_valid_o;
  logic        commit_o, mem_wr_en_o, trap_o;
  logic [3:0]  cause_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  exc_pipe_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .stg_exc_i(stg_exc_i), .stg_cause_i(stg_cause_i),
    .irq_i(irq_i), .eret_i(eret_i), .fetch_pc_o(fetch_pc_o), .stage_valid_o(stage_valid_o),
    .wb_pc_o(wb_pc_o), .commit_o(commit_o), .mem_wr_en_o(mem_wr_en_o), .trap_o(trap_o),
    .epc_o(epc_o), .cause_o(cause_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    stg_exc_i = '0; stg_cause_i = '0; irq_i = 1'b0; eret_i = 1'b0;
  endtask

  // advance one cycle; inputs cleared right after the negedge
  task automatic nxt();
    @(negedge clk_i);
    clr_in();
  endtask

  // reset released at a negedge: that window is cycle 0 (fetch holds 0)
  task automatic do_reset();
    clr_in();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    clr_in();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    #1;
    check("R1 fetch pc in reset", fetch_pc_o, 32'h0);
    check("R1 valid in reset", 32'(stage_valid_o), 32'h1);
    check("R1 epc", epc_o, 32'h0);
    check("R1 cause", 32'(cause_o), 32'h0);
    check("R1 trap/commit", {30'b0, trap_o, commit_o}, 32'h0);
    do_reset();
    check("R1 valid after release", 32'(stage_valid_o), 32'h1);
  endtask

  task automatic t_flow();
    do_reset();
    for (int n = 0; n < 8; n++) begin
      if (n > 0) nxt();
      #1;
      check("R2 fetch step", fetch_pc_o, 32'(4 * n));
      check("R2 commit", 32'(commit_o), 32'(n >= 4));
      if (n >= 4) check("R2 wb pc", wb_pc_o, 32'(4 * (n - 4)));
      if (n == 3) check("R4 write enabled clean", 32'(mem_wr_en_o), 32'h1);
    end
  endtask

  // memory fault on pc 8 (memory stage in cycle 5), then return
  task automatic t_mem_fault();
    do_reset();
    for (int n = 0; n < 18; n++) begin
      if (n > 0) nxt();
      if (n == 5) begin stg_exc_i = 4'b1000; stg_cause_i = 16'h5000; end
      if (n == 7) begin stg_exc_i = 4'b1110; stg_cause_i = 16'h7770; end
      if (n == 12) eret_i = 1'b1;
      #1;
      case (n)
        5: begin
          check("R4 write blocked on fault", 32'(mem_wr_en_o), 32'h0);
          check("R3 no trap before wb", 32'(trap_o), 32'h0);
          check("R5 older commits", {commit_o, wb_pc_o[30:0]}, {1'b1, 31'h4});
        end
        6: begin
          check("R3 trap at wb", 32'(trap_o), 32'h1);
          check("R5 faulting not committed", 32'(commit_o), 32'h0);
          check("R5 wb pc", wb_pc_o, 32'h8);
          check("R4 younger write blocked on trap", 32'(mem_wr_en_o), 32'h0);
        end
        7: begin
          check("R6 fetch at vector", fetch_pc_o, 32'h80);
          check("R5 younger flushed", 32'(stage_valid_o), 32'h1);
          check("R7 epc", epc_o, 32'h8);
          check("R7 cause", 32'(cause_o), 32'h5);
        end
        8, 9, 10: check("R12 no commit or trap after flush", {30'b0, trap_o, commit_o}, 32'h0);
        11: begin
          check("R12 empty-stage flags ignored", 32'(trap_o), 32'h0);
          check("R6 vector reaches wb", {commit_o, wb_pc_o[30:0]}, {1'b1, 31'h80});
        end
        13: begin
          check("R11 resume at epc", fetch_pc_o, 32'h8);
          check("R11 flush on return", 32'(stage_valid_o), 32'h1);
          check("R7 epc held", epc_o, 32'h8);
        end
        17: check("R11 restarted commits", {commit_o, wb_pc_o[30:0]}, {1'b1, 31'h8});
        default: ;
      endcase
    end
  endtask

  task automatic t_order();
    do_reset();
    for (int n = 0; n < 8; n++) begin
      if (n > 0) nxt();
      if (n == 5) begin stg_exc_i = 4'b1101; stg_cause_i = 16'h5302; end
      #1;
      if (n == 6) check("R8 oldest taken", {trap_o, wb_pc_o[30:0]}, {1'b1, 31'h8});
      if (n == 7) begin
        check("R8 epc oldest", epc_o, 32'h8);
        check("R8 cause oldest", 32'(cause_o), 32'h5);
      end
    end
  endtask

  task automatic t_first_cause();
    do_reset();
    for (int n = 0; n < 8; n++) begin
      if (n > 0) nxt();
      if (n == 2) begin stg_exc_i = 4'b0001; stg_cause_i = 16'h0001; end
      if (n == 4) begin stg_exc_i = 4'b0100; stg_cause_i = 16'h0300; end
      #1;
      if (n == 5) check("R4 write blocked by recorded fault", 32'(mem_wr_en_o), 32'h0);
      if (n == 7) begin
        check("R9 first cause kept", 32'(cause_o), 32'h1);
        check("R9 epc", epc_o, 32'h8);
      end
    end
  endtask

  task automatic t_irq(input bit with_id);
    do_reset();
    for (int n = 0; n < 8; n++) begin
      if (n > 0) nxt();
      if (n == 3) begin
        irq_i = 1'b1;
        if (with_id) begin stg_exc_i = 4'b0010; stg_cause_i = 16'h0060; end
      end
      #1;
      if (n == 5) check("R10 older commits", {commit_o, wb_pc_o[30:0]}, {1'b1, 31'h4});
      if (n == 7) begin
        check("R10 irq epc", epc_o, 32'h8);
        check("R10 irq cause", 32'(cause_o), with_id ? 32'h6 : 32'hF);
      end
    end
  endtask

  task automatic t_trap_vs_eret();
    do_reset();
    for (int n = 0; n < 8; n++) begin
      if (n > 0) nxt();
      if (n == 5) begin stg_exc_i = 4'b1000; stg_cause_i = 16'h9000; end
      if (n == 6) eret_i = 1'b1;
      #1;
      if (n == 7) check("R11 trap outranks return", fetch_pc_o, 32'h80);
    end
  endtask

  initial begin
    t_reset();
    t_flow();
    t_mem_fault();
    t_order();
    t_first_cause();
    t_irq(1'b0);
    t_irq(1'b1);
    t_trap_vs_eret();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule